// File: doc/BRIEF.md
# Broadcast Output Routing Selector

This block decides, on every clock, which programme source each of the four audio channel outputs carries. There are two stereo output pairs: a line pair and a speaker pair. The inputs are the detected broadcast type (stereo flag and bilingual flag), a forced-mono request, a two-bit programme selection, one unmute bit for each pair, an auxiliary-input request for the speaker pair and a factory test request for the line pair. For each channel the block produces a 3-bit source code. The analog switch fabric downstream decodes this code.

The routing has three levels of precedence. A cleared unmute bit silences its pair before anything else is considered. After that, the per-pair override applies: test for the line pair, auxiliary input for the speaker pair. Only when no override is active does a pair carry the broadcast routing. The broadcast routing depends on the detected mode, the forced-mono bit and the programme selection. All four codes are registered, so the switches see one clean change per clock edge and never a decoding transient.

Top module: `route_select`

## Requirements
- R1: While `line_unmute` is 0, both line codes are 0 (mute), whatever any other input is, including `test_mode`.
- R2: While `spk_unmute` is 0, both speaker codes are 0 (mute), whatever any other input is, including `aux_select`.
- R3: With a mono input (`det_stereo`=0, `det_bilingual`=0), both channels of an unmuted, non-overridden pair carry code 1 (main), whatever the values of `force_mono` and `prog_sel`.
- R4: With a stereo input (`det_stereo`=1, `det_bilingual`=0) and `force_mono`=1, both channels carry code 5 (left+right), for every `prog_sel`.
- R5: With a stereo input and `force_mono`=0, the left channel carries code 3 (left) and the right channel carries code 4 (right), for all four `prog_sel` values.
- R6: With `det_bilingual`=1 (this takes precedence over `det_stereo`), the codes depend on `prog_sel`. `prog_sel`=00 gives 1/1 (main/main). 01 gives 2/2 (sub/sub). 10 and 11 both give 1/2 (main left, sub right). `force_mono` has no effect.
- R7: `aux_select`=1 sets both speaker codes to 6 (auxiliary). The line pair keeps its broadcast routing.
- R8: `test_mode`=1 sets both line codes to 7 (test). On the line pair, code 7 means the filtered pilot on the left and the gain-DAC test voltage on the right. The speaker pair is unaffected.
- R9: A synchronous active-low reset (`rst_n`=0 at a rising edge) drives all four codes to 0 (mute).
- R10: Every code is registered. It takes the value implied by the inputs sampled at the most recent rising edge and does not change between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| det_stereo | input | 1 | Stereo broadcast detected |
| det_bilingual | input | 1 | Bilingual broadcast detected |
| force_mono | input | 1 | Forced-mono request |
| prog_sel | input | 2 | Programme selection (bit 1 high, bit 0 low) |
| line_unmute | input | 1 | 1 lets the line pair play, 0 mutes it |
| spk_unmute | input | 1 | 1 lets the speaker pair play, 0 mutes it |
| aux_select | input | 1 | Speaker pair takes the auxiliary input |
| test_mode | input | 1 | Line pair carries the test signals |
| line_l_src | output | 3 | Line left source code |
| line_r_src | output | 3 | Line right source code |
| spk_l_src | output | 3 | Speaker left source code |
| spk_r_src | output | 3 | Speaker right source code |

## Verification
Mute and override can be requested in the same cycle. The vector table sets the unmute bit to 0 together with `test_mode` or `aux_select`, and expects code 0 on that pair, while the other pair keeps its own override or routing code. A second collision is a broadcast mode change in the same cycle as an override. Its check expects the overridden pair to show the override code and the other pair to show the new mode's routing. Every expected code is compared one edge after the stimulus is applied.

// File: rtl/route_pkg.sv
// Shared definitions for the broadcast output routing selector.
// Assumes one source code per channel, decoded downstream by the switches.
package route_pkg;
    localparam int SRC_W = 3;
    localparam int N_CH  = 4;
    localparam int SEL_W = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_MUTE  = 3'd0,
        SRC_MAIN  = 3'd1,
        SRC_SUB   = 3'd2,
        SRC_LEFT  = 3'd3,
        SRC_RIGHT = 3'd4,
        SRC_SUM   = 3'd5,
        SRC_AUX   = 3'd6,
        SRC_TEST  = 3'd7
    } src_e;
endpackage

// File: rtl/route_mode_decode.sv
// Broadcast routing decoder: maps detected mode, forced mono and programme
// selection to a left/right source pair. Purely combinational.
// Assumes bilingual detection has priority over stereo detection.
module route_mode_decode
    import route_pkg::*;
(
    input  logic             det_stereo,
    input  logic             det_bilingual,
    input  logic             force_mono,
    input  logic [SEL_W-1:0] prog_sel,
    output src_e             tv_l,
    output src_e             tv_r
);
    // Pick the broadcast routing for the current mode.
    always_comb begin
        tv_l = SRC_MAIN;
        tv_r = SRC_MAIN;
        if (det_bilingual) begin
            unique case (prog_sel)
                2'b00:   begin tv_l = SRC_MAIN; tv_r = SRC_MAIN; end
                2'b01:   begin tv_l = SRC_SUB;  tv_r = SRC_SUB;  end
                default: begin tv_l = SRC_MAIN; tv_r = SRC_SUB;  end
            endcase
        end else if (det_stereo) begin
            if (force_mono) begin
                tv_l = SRC_SUM;
                tv_r = SRC_SUM;
            end else begin
                tv_l = SRC_LEFT;
                tv_r = SRC_RIGHT;
            end
        end
    end

    // Guard the decoder's mode separation.
    always_comb begin
        a_r6_bil_only_main_sub: assert (!det_bilingual ||
            ((tv_l == SRC_MAIN) && (tv_r inside {SRC_MAIN, SRC_SUB})) ||
            ((tv_l == SRC_SUB) && (tv_r == SRC_SUB)));
        a_r3_mono_main: assert (det_bilingual || det_stereo ||
            ((tv_l == SRC_MAIN) && (tv_r == SRC_MAIN)));
        a_r4_sum_pair: assert (!(det_stereo && !det_bilingual && force_mono) ||
            ((tv_l == SRC_SUM) && (tv_r == SRC_SUM)));
    end
endmodule

// File: rtl/route_pair_gate.sv
// Per-pair gating: applies the pair's mute, then its override, then falls
// back to the broadcast routing. OVR_IS_TEST picks the override code
// (test for the line pair, auxiliary for the speaker pair).
module route_pair_gate
    import route_pkg::*;
#(
    parameter bit OVR_IS_TEST = 1'b1
) (
    input  logic unmute,
    input  logic override_req,
    input  src_e base_l,
    input  src_e base_r,
    output src_e pair_l,
    output src_e pair_r
);
    src_e ovr_l;
    src_e ovr_r;

    generate
        if (OVR_IS_TEST) begin : g_test
            assign ovr_l = SRC_TEST;
            assign ovr_r = SRC_TEST;
        end else begin : g_aux
            assign ovr_l = SRC_AUX;
            assign ovr_r = SRC_AUX;
        end
    endgenerate

    // Resolve mute > override > broadcast routing.
    always_comb begin
        if (!unmute) begin
            pair_l = SRC_MUTE;
            pair_r = SRC_MUTE;
        end else if (override_req) begin
            pair_l = ovr_l;
            pair_r = ovr_r;
        end else begin
            pair_l = base_l;
            pair_r = base_r;
        end
    end

    // Guard that a muted pair is silent on both channels.
    always_comb begin
        a_r1_pair_mute_silent: assert (unmute ||
            ((pair_l == SRC_MUTE) && (pair_r == SRC_MUTE)));
    end
endmodule

// File: rtl/route_out_reg.sv
// Output register bank: one register per channel code, synchronous
// active-low reset to mute. Assumes codes are packed channel-major.
module route_out_reg #(
    parameter int N   = 4,
    parameter int W   = 3,
    localparam int TW = N * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] d,
    output logic [TW-1:0] q
);
    genvar ch;
    generate
        for (ch = 0; ch < N; ch++) begin : g_ch
            // Hold one channel's code, cleared to mute in reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q[ch*W +: W] <= '0;
                else        q[ch*W +: W] <= d[ch*W +: W];
            end
        end
    endgenerate
endmodule

// File: rtl/route_select.sv
// Top of the broadcast output routing selector: decodes broadcast routing,
// gates it per output pair and registers the four channel codes.
// Assumes all inputs are synchronous to clk.
module route_select
    import route_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             det_stereo,
    input  logic             det_bilingual,
    input  logic             force_mono,
    input  logic [SEL_W-1:0] prog_sel,
    input  logic             line_unmute,
    input  logic             spk_unmute,
    input  logic             aux_select,
    input  logic             test_mode,
    output logic [SRC_W-1:0] line_l_src,
    output logic [SRC_W-1:0] line_r_src,
    output logic [SRC_W-1:0] spk_l_src,
    output logic [SRC_W-1:0] spk_r_src
);
    localparam int TW = N_CH * SRC_W;

    src_e tv_l, tv_r;
    src_e ln_l, ln_r, sp_l, sp_r;
    logic [TW-1:0] next_codes;
    logic [TW-1:0] reg_codes;

    route_mode_decode u_decode (
        .det_stereo   (det_stereo),
        .det_bilingual(det_bilingual),
        .force_mono   (force_mono),
        .prog_sel     (prog_sel),
        .tv_l         (tv_l),
        .tv_r         (tv_r)
    );

    route_pair_gate #(.OVR_IS_TEST(1'b1)) u_line_gate (
        .unmute      (line_unmute),
        .override_req(test_mode),
        .base_l      (tv_l),
        .base_r      (tv_r),
        .pair_l      (ln_l),
        .pair_r      (ln_r)
    );

    route_pair_gate #(.OVR_IS_TEST(1'b0)) u_spk_gate (
        .unmute      (spk_unmute),
        .override_req(aux_select),
        .base_l      (tv_l),
        .base_r      (tv_r),
        .pair_l      (sp_l),
        .pair_r      (sp_r)
    );

    // Pack channel codes: speaker right in the top slot, line left at the bottom.
    always_comb begin
        next_codes = {sp_r, sp_l, ln_r, ln_l};
    end

    route_out_reg #(.N(N_CH), .W(SRC_W)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (next_codes),
        .q    (reg_codes)
    );

    assign line_l_src = reg_codes[0*SRC_W +: SRC_W];
    assign line_r_src = reg_codes[1*SRC_W +: SRC_W];
    assign spk_l_src  = reg_codes[2*SRC_W +: SRC_W];
    assign spk_r_src  = reg_codes[3*SRC_W +: SRC_W];

    // R9: reset leaves every code at mute.
    a_r9_reset_mute: assert property (@(posedge clk)
        !$past(rst_n) |-> (line_l_src == 3'd0 && line_r_src == 3'd0 &&
                           spk_l_src == 3'd0 && spk_r_src == 3'd0));

    // R1: a muted line pair is silent on the next cycle.
    a_r1_line_mute: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(line_unmute)) |->
            (line_l_src == 3'd0 && line_r_src == 3'd0));

    // R2: a muted speaker pair is silent on the next cycle.
    a_r2_spk_mute: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(spk_unmute)) |->
            (spk_l_src == 3'd0 && spk_r_src == 3'd0));

    // R7: an unmuted speaker pair with the auxiliary request carries auxiliary.
    a_r7_spk_aux: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(spk_unmute) && $past(aux_select)) |->
            (spk_l_src == 3'd6 && spk_r_src == 3'd6));

    // R8: an unmuted line pair in test carries the test code on both channels.
    a_r8_line_test: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(line_unmute) && $past(test_mode)) |->
            (line_l_src == 3'd7 && line_r_src == 3'd7));

    // R10: with inputs held, the codes hold.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(det_stereo) && $stable(det_bilingual) &&
         $stable(force_mono) && $stable(prog_sel) && $stable(line_unmute) &&
         $stable(spk_unmute) && $stable(aux_select) && $stable(test_mode))
        |=> ($stable(line_l_src) && $stable(line_r_src) &&
             $stable(spk_l_src) && $stable(spk_r_src)));
endmodule

// File: tb/route_select_test.sv
module route_select_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic det_stereo = 1'b0, det_bilingual = 1'b0, force_mono = 1'b0;
    logic [1:0] prog_sel = 2'b00;
    logic line_unmute = 1'b1, spk_unmute = 1'b1, aux_select = 1'b0, test_mode = 1'b0;
    logic [2:0] line_l_src, line_r_src, spk_l_src, spk_r_src;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    route_select uut (
        .clk(clk), .rst_n(rst_n),
        .det_stereo(det_stereo), .det_bilingual(det_bilingual),
        .force_mono(force_mono), .prog_sel(prog_sel),
        .line_unmute(line_unmute), .spk_unmute(spk_unmute),
        .aux_select(aux_select), .test_mode(test_mode),
        .line_l_src(line_l_src), .line_r_src(line_r_src),
        .spk_l_src(spk_l_src), .spk_r_src(spk_r_src)
    );

    // Vector: {req[3:0], st, bil, fomo, s1, s0, line_unmute, spk_unmute, aux, test,
    //          exp line_l, line_r, spk_l, spk_r}
    localparam int NV = 22;
    localparam logic [24:0] VEC [NV] = '{
        {4'd3,  9'b00000_1100, 12'o1111},  // R3 mono
        {4'd3,  9'b00110_1100, 12'o1111},  // R3 mono, fomo and sel ignored
        {4'd4,  9'b10100_1100, 12'o5555},  // R4 stereo forced mono
        {4'd4,  9'b10110_1100, 12'o5555},  // R4 stereo forced mono sel 10
        {4'd5,  9'b10000_1100, 12'o3434},  // R5 stereo 00
        {4'd5,  9'b10001_1100, 12'o3434},  // R5 stereo 01
        {4'd5,  9'b10010_1100, 12'o3434},  // R5 stereo 10
        {4'd5,  9'b10011_1100, 12'o3434},  // R5 stereo 11
        {4'd6,  9'b01000_1100, 12'o1111},  // R6 bilingual 00
        {4'd6,  9'b01001_1100, 12'o2222},  // R6 bilingual 01
        {4'd6,  9'b01010_1100, 12'o1212},  // R6 bilingual 10
        {4'd6,  9'b01011_1100, 12'o1212},  // R6 bilingual 11
        {4'd6,  9'b01101_1100, 12'o2222},  // R6 bilingual fomo ignored
        {4'd6,  9'b11010_1100, 12'o1212},  // R6 bilingual beats stereo
        {4'd1,  9'b10000_0100, 12'o0034},  // R1 line muted
        {4'd2,  9'b01001_1000, 12'o2200},  // R2 speaker muted
        {4'd7,  9'b10000_1110, 12'o3466},  // R7 aux on speaker, line stereo
        {4'd8,  9'b01010_1101, 12'o7712},  // R8 test on line, speaker bilingual
        {4'd8,  9'b00000_1111, 12'o7766},  // R8 test and aux together
        {4'd1,  9'b00000_0101, 12'o0011},  // R1 mute beats test
        {4'd2,  9'b00000_1010, 12'o1100},  // R2 mute beats aux
        {4'd1,  9'b10100_0011, 12'o0000}   // R1 R2 both muted with overrides
    };

    function automatic logic [11:0] outs();
        return {line_l_src, line_r_src, spk_l_src, spk_r_src};
    endfunction

    task automatic check(input string tag, input logic [11:0] exp);
        checks++;
        if (outs() !== exp) begin
            failures++;
            $display("FAIL %s actual=%o expected=%o", tag, outs(), exp);
        end
    endtask

    task automatic drive(input logic [8:0] v);
        {det_stereo, det_bilingual, force_mono, prog_sel,
         line_unmute, spk_unmute, aux_select, test_mode} = v;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R9: reset with non-mute inputs applied gives all mute.
        drive(9'b10000_1111);
        @(negedge clk);
        @(negedge clk);
        check("R9 reset state", 12'o0000);
        rst_n = 1'b1;

        // Table walk: drive at negedge, result after one rising edge.
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][20:12]);
            @(negedge clk);
            checks++;
            if (outs() !== VEC[i][11:0]) begin
                failures++;
                $display("FAIL R%0d vector %0d actual=%o expected=%o",
                         VEC[i][24:21], i, outs(), VEC[i][11:0]);
            end
        end

        // R10: a change is not visible before the next rising edge.
        drive(9'b00000_1100);
        @(negedge clk);
        check("R10 settle mono", 12'o1111);
        drive(9'b10000_1100);
        #2;
        check("R10 before edge", 12'o1111);
        @(negedge clk);
        check("R10 after edge", 12'o3434);
        @(negedge clk);
        check("R10 held", 12'o3434);

        // R9: reset in mid-run clears the codes.
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid-run reset", 12'o0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 exit reset", 12'o3434);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule